// File: doc/BRIEF.md
# Record-Form Condition Field Generator

This block produces the 4-bit condition field that a record-form ("dot") integer instruction writes. A small front end adds or combines two 64-bit operands. The result is then compared with zero as a signed value. In 64-bit mode the compare uses the whole result. In 32-bit mode it uses only the low word. The comparison always looks at the wrapped result, never at the infinitely precise one. The block also holds the overflow bit and the sticky summary-overflow bit, and it copies the summary bit into the field.

Each accepted instruction is registered, so the result, the field, its write-enable and the status bits all appear on the cycle after issue. A store-conditional instruction does not use the compare rule. Its field is taken as-is from a side input, and it leaves the overflow state untouched.

Top module: `crf_gen`

## Requirements
- R1: The field write-enable `o_cr_we` is high in the cycle after an issue with `i_valid` and `i_rec` both high, and low otherwise. When no write occurs, `o_cr_fld` keeps its value, even if the instruction changed the result or the overflow state.
- R2: Field layout is `o_cr_fld[3]`=less-than, `[2]`=greater-than, `[1]`=equal, `[0]`=summary copy. In 64-bit mode (`i_mode64`=1): less-than is result bit 63; equal means all 64 bits are zero; greater-than means nonzero with bit 63 clear.
- R3: In 32-bit mode (`i_mode64`=0) the compare uses only result bits 31:0, with bit 31 as the sign. Bits 63:32 have no effect on the field.
- R4: Logical operations are compared as signed too. Operation codes on `i_op`: 0=add, 1=and, 2=or, 3=nor.
- R5: The sign bits reflect the wrapped result. A positive add that overflows sets less-than.
- R6: Adding the most negative value of the active width to itself yields zero and sets equal, together with overflow.
- R7: An add overflows when both operands carry the same sign at the active width and the result sign differs. Logic operations never overflow. With `i_ovf_upd`=1, `o_ov` is rewritten with this instruction's overflow.
- R8: `o_so` is sticky. It is set by an instruction with `i_ovf_upd`=1 that overflows. Only `i_so_clr` clears it, and `i_so_clr` also clears `o_ov`. If a clear and a setting overflow arrive in the same cycle, the set wins.
- R9: In a written field that is not a store-conditional, bit 0 equals the summary bit after the instruction's own update, i.e. `o_so` in the same output cycle.
- R10: An instruction with `i_ovf_upd`=0 leaves `o_ov` and `o_so` unchanged, even if it overflows. Its field bit 0 is the prior summary value.
- R11: With `i_stcx`=1 the written field equals `i_stcx_fld` unchanged, and `o_ov`/`o_so` are not updated by the instruction.
- R12: Synchronous reset `rst` clears `o_result`, `o_cr_we`, `o_cr_fld`, `o_ov` and `o_so` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Instruction issue strobe |
| i_rec | input | 1 | Record form: write the condition field |
| i_mode64 | input | 1 | 1 = 64-bit compare width, 0 = 32-bit |
| i_op | input | 2 | Operation: 0 add, 1 and, 2 or, 3 nor |
| i_opa | input | 64 | First operand |
| i_opb | input | 64 | Second operand |
| i_ovf_upd | input | 1 | Instruction updates overflow and summary bits |
| i_stcx | input | 1 | Store-conditional class: field from side input |
| i_stcx_fld | input | 4 | Field supplied for store-conditional |
| i_so_clr | input | 1 | Clear summary-overflow and overflow bits |
| o_result | output | 64 | Registered operation result |
| o_cr_we | output | 1 | Condition-field write-enable |
| o_cr_fld | output | 4 | Condition field |
| o_so | output | 1 | Sticky summary-overflow bit |
| o_ov | output | 1 | Overflow bit |

## Verification
The summary-bit clear and an overflowing add with `i_ovf_upd` set can land in the same cycle. In that case the outcome decides both `o_so` and bit 0 of the field written by that same instruction. The bench drives `i_so_clr` together with an overflowing add, and then together with a non-overflowing add. The scoreboard expects the summary bit set after the first and clear after the second, with the field copy matching `o_so` both times. A standalone clear that writes no field is also driven, and the held field is checked against the last written value.

// File: rtl/crf_pkg.sv
package crf_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_AND = 2'd1,
        OP_OR  = 2'd2,
        OP_NOR = 2'd3
    } crf_op_e;

    // packed: first member lands in the top bit of the 4-bit field
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } crf_field_t;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
    } crf_sign_t;

    function automatic crf_sign_t classify(input logic msb, input logic zero);
        crf_sign_t s;
        s.lt = msb;
        s.gt = !msb && !zero;
        s.eq = zero;
        return s;
    endfunction

endpackage

// File: rtl/crf_alu_front.sv
module crf_alu_front
    import crf_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  crf_op_e           op,
    input  logic              mode64,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    output logic [XLEN-1:0]   res,
    output logic              ovf
);
    localparam int HALF = XLEN / 2;

    logic sa, sb, sr;

    always_comb begin
        unique case (op)
            OP_ADD:  res = a + b;
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            default: res = ~(a | b);
        endcase
        sa  = mode64 ? a[XLEN-1]   : a[HALF-1];
        sb  = mode64 ? b[XLEN-1]   : b[HALF-1];
        sr  = mode64 ? res[XLEN-1] : res[HALF-1];
        ovf = (op == OP_ADD) && (sa == sb) && (sr != sa);
    end
endmodule

// File: rtl/crf_cmp_zero.sv
module crf_cmp_zero
    import crf_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] res,
    input  logic            mode64,
    output crf_sign_t       sgn
);
    localparam int HALF = XLEN / 2;

    logic msb, zero;

    always_comb begin
        msb  = mode64 ? res[XLEN-1] : res[HALF-1];
        zero = mode64 ? (res == '0) : (res[HALF-1:0] == '0);
        sgn  = classify(msb, zero);
    end
endmodule

// File: rtl/crf_ovf_state.sv
module crf_ovf_state (
    input  logic clk,
    input  logic rst,
    input  logic upd,
    input  logic ovf,
    input  logic clr,
    output logic so_next,
    output logic so_q,
    output logic ov_q
);
    logic ov_next;

    always_comb begin
        so_next = (so_q && !clr) || (upd && ovf);
        if (upd)      ov_next = ovf;
        else if (clr) ov_next = 1'b0;
        else          ov_next = ov_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            so_q <= 1'b0;
            ov_q <= 1'b0;
        end else begin
            so_q <= so_next;
            ov_q <= ov_next;
        end
    end

    // R8: summary stays set unless cleared
    a_r8_sticky_so: assert property (@(posedge clk) disable iff (rst)
        (so_q && !clr) |=> so_q);

    // R8: a setting overflow wins over a same-cycle clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (upd && ovf) |=> (so_q && ov_q));

    // R10: no update and no clear leaves the overflow bit alone
    a_r10_ov_hold: assert property (@(posedge clk) disable iff (rst)
        (!upd && !clr) |=> $stable(ov_q));
endmodule

// File: rtl/crf_gen.sv
module crf_gen
    import crf_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             i_valid,
    input  logic             i_rec,
    input  logic             i_mode64,
    input  logic [1:0]       i_op,
    input  logic [XLEN-1:0]  i_opa,
    input  logic [XLEN-1:0]  i_opb,
    input  logic             i_ovf_upd,
    input  logic             i_stcx,
    input  logic [3:0]       i_stcx_fld,
    input  logic             i_so_clr,
    output logic [XLEN-1:0]  o_result,
    output logic             o_cr_we,
    output logic [3:0]       o_cr_fld,
    output logic             o_so,
    output logic             o_ov
);
    logic [XLEN-1:0] alu_res;
    logic            alu_ovf;
    crf_sign_t       sgn;
    logic            so_next;
    logic            upd;
    logic            wr;
    crf_field_t      fld_d, fld_q;
    logic [XLEN-1:0] res_q;
    logic            we_q, stcx_q;

    crf_alu_front #(.XLEN(XLEN)) u_alu (
        .op(crf_op_e'(i_op)), .mode64(i_mode64), .a(i_opa), .b(i_opb),
        .res(alu_res), .ovf(alu_ovf)
    );

    crf_cmp_zero #(.XLEN(XLEN)) u_cmp (
        .res(alu_res), .mode64(i_mode64), .sgn(sgn)
    );

    assign upd = i_valid && i_ovf_upd && !i_stcx;
    assign wr  = i_valid && i_rec;

    crf_ovf_state u_st (
        .clk(clk), .rst(rst), .upd(upd), .ovf(alu_ovf), .clr(i_so_clr),
        .so_next(so_next), .so_q(o_so), .ov_q(o_ov)
    );

    always_comb begin
        if (i_stcx) fld_d = crf_field_t'(i_stcx_fld);
        else        fld_d = '{lt: sgn.lt, gt: sgn.gt, eq: sgn.eq, so: so_next};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            we_q   <= 1'b0;
            fld_q  <= '0;
            stcx_q <= 1'b0;
        end else begin
            we_q <= wr;
            if (i_valid) res_q <= alu_res;
            if (wr) begin
                fld_q  <= fld_d;
                stcx_q <= i_stcx;
            end
        end
    end

    assign o_result = res_q;
    assign o_cr_we  = we_q;
    assign o_cr_fld = fld_q;

    // R1: a record-form issue raises the write-enable next cycle
    a_r1_we_follows: assert property (@(posedge clk) disable iff (rst)
        wr |=> o_cr_we);

    // R1: without a write the field holds
    a_r1_field_hold: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(o_cr_fld));

    // R2: exactly one relation flag in a compare-produced field
    a_r2_one_flag: assert property (@(posedge clk) disable iff (rst)
        (o_cr_we && !stcx_q) |-> $onehot(o_cr_fld[3:1]));

    // R9: field summary copy matches the sticky bit after the update
    a_r9_so_copy: assert property (@(posedge clk) disable iff (rst)
        (o_cr_we && !stcx_q) |-> (o_cr_fld[0] == o_so));

    // R11: store-conditional field passes through
    a_r11_stcx_pass: assert property (@(posedge clk) disable iff (rst)
        (wr && i_stcx) |=> (o_cr_fld == $past(i_stcx_fld)));
endmodule

// File: tb/sim_crf_gen.sv
module sim_crf_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        i_valid = 0, i_rec = 0, i_mode64 = 1;
    logic [1:0]  i_op = 0;
    logic [63:0] i_opa = 0, i_opb = 0;
    logic        i_ovf_upd = 0, i_stcx = 0, i_so_clr = 0;
    logic [3:0]  i_stcx_fld = 0;
    logic [63:0] o_result;
    logic        o_cr_we;
    logic [3:0]  o_cr_fld;
    logic        o_so, o_ov;

    always #(CLK_PERIOD/2) clk = ~clk;

    crf_gen u0 (
        .clk(clk), .rst(rst), .i_valid(i_valid), .i_rec(i_rec),
        .i_mode64(i_mode64), .i_op(i_op), .i_opa(i_opa), .i_opb(i_opb),
        .i_ovf_upd(i_ovf_upd), .i_stcx(i_stcx), .i_stcx_fld(i_stcx_fld),
        .i_so_clr(i_so_clr), .o_result(o_result), .o_cr_we(o_cr_we),
        .o_cr_fld(o_cr_fld), .o_so(o_so), .o_ov(o_ov)
    );

    typedef struct {
        logic [63:0] res;
        logic        we;
        logic [3:0]  fld;
        logic        so;
        logic        ov;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    logic [63:0] m_res = 0;
    logic [3:0]  m_fld = 0;
    logic        m_so = 0, m_ov = 0;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic send(input bit valid, input bit rec, input bit m64,
                        input logic [1:0] op, input logic [63:0] a,
                        input logic [63:0] b, input bit oe, input bit stcx,
                        input logic [3:0] sfld, input bit clr, input string tag);
        logic [63:0] r;
        logic msb, zero, sa, sb, ovf, upd;
        exp_t e;
        case (op)
            2'd0: r = a + b;
            2'd1: r = a & b;
            2'd2: r = a | b;
            default: r = ~(a | b);
        endcase
        msb  = m64 ? r[63] : r[31];
        zero = m64 ? (r == 0) : (r[31:0] == 0);
        sa   = m64 ? a[63] : a[31];
        sb   = m64 ? b[63] : b[31];
        ovf  = (op == 2'd0) && (sa == sb) && (msb != sa);
        upd  = valid && oe && !stcx;
        if (clr) begin m_so = 0; m_ov = 0; end
        if (upd) begin m_ov = ovf; if (ovf) m_so = 1; end
        if (valid) m_res = r;
        if (valid && rec)
            m_fld = stcx ? sfld : {msb, !msb && !zero, zero, m_so};
        e.res = m_res; e.we = valid && rec; e.fld = m_fld;
        e.so = m_so; e.ov = m_ov; e.tag = tag;

        @(negedge clk);
        i_valid = valid; i_rec = rec; i_mode64 = m64; i_op = op;
        i_opa = a; i_opb = b; i_ovf_upd = oe; i_stcx = stcx;
        i_stcx_fld = sfld; i_so_clr = clr;
        @(posedge clk);
        q.push_back(e);
    endtask

    // monitor: compare one registered result per cycle
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, "result", o_result, e.res);
            chk(e.tag, "we",     {63'd0, o_cr_we}, {63'd0, e.we});
            chk(e.tag, "field",  {60'd0, o_cr_fld}, {60'd0, e.fld});
            chk(e.tag, "so",     {63'd0, o_so}, {63'd0, e.so});
            chk(e.tag, "ov",     {63'd0, o_ov}, {63'd0, e.ov});
        end
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R12: reset state
        chk("R12", "result", o_result, 64'd0);
        chk("R12", "flags", {59'd0, o_cr_we, o_cr_fld}, 64'd0);
        chk("R12", "so_ov", {62'd0, o_so, o_ov}, 64'd0);

        // R2: 64-bit compare, positive, negative, zero
        send(1,1,1,2'd0,64'd5,64'd7,0,0,4'd0,0,"R2_gt");
        send(1,1,1,2'd0,64'd3,-64'sd10,0,0,4'd0,0,"R2_lt");
        send(1,1,1,2'd0,64'd0,64'd0,0,0,4'd0,0,"R2_eq");
        // R3: 32-bit mode ignores upper word
        send(1,1,0,2'd2,64'hFFFF_FFFF_0000_0000,64'd0,0,0,4'd0,0,"R3_eq");
        send(1,1,0,2'd2,64'h0000_0001_8000_0000,64'd0,0,0,4'd0,0,"R3_lt");
        send(1,1,0,2'd1,64'h8000_0000_7FFF_FFFF,64'hFFFF_FFFF_FFFF_FFFF,0,0,4'd0,0,"R3_gt");
        // R4: logic ops compared signed
        send(1,1,1,2'd3,64'd0,64'd0,0,0,4'd0,0,"R4_nor_lt");
        send(1,1,1,2'd1,64'hF0,64'h0F,0,0,4'd0,0,"R4_and_eq");
        // R5/R7/R9: positive overflow with update
        send(1,1,1,2'd0,64'h7FFF_FFFF_FFFF_FFFF,64'd1,1,0,4'd0,0,"R5_R7_R9_ovf");
        // R7/R8: next update without overflow rewrites ov, so stays
        send(1,1,1,2'd0,64'd1,64'd1,1,0,4'd0,0,"R7_R8_sticky");
        // R8/R1: clear alone, no field write
        send(0,0,1,2'd0,64'd0,64'd0,0,0,4'd0,1,"R8_R1_clear");
        // R6/R10: most negative doubled in 32-bit, no update
        send(1,1,0,2'd0,64'h8000_0000,64'h8000_0000,0,0,4'd0,0,"R6_R10_eq32");
        // R6: most negative doubled in 64-bit with update
        send(1,1,1,2'd0,64'h8000_0000_0000_0000,64'h8000_0000_0000_0000,1,0,4'd0,0,"R6_eq64");
        // R8: clear and setting overflow together
        send(1,1,1,2'd0,64'h7FFF_FFFF_FFFF_FFFF,64'd1,1,0,4'd0,1,"R8_clr_set");
        // R8: clear together with non-overflowing update
        send(1,1,1,2'd0,64'd2,64'd2,1,0,4'd0,1,"R8_clr_noovf");
        // R1: no record form -> field held, ov still updated
        send(1,0,1,2'd0,64'h7FFF_FFFF_FFFF_FFFF,64'd1,1,0,4'd0,0,"R1_norec");
        // R10: overflow without update leaves so/ov
        send(1,1,0,2'd0,64'h7FFF_FFFF,64'd1,0,0,4'd0,1,"R10_clrfirst");
        send(1,1,0,2'd0,64'h7FFF_FFFF,64'd1,0,0,4'd0,0,"R10_noupd");
        // R11: store-conditional passes side field, ignores overflow
        send(1,1,1,2'd0,64'h7FFF_FFFF_FFFF_FFFF,64'd1,1,1,4'b0011,0,"R11_stcx");
        send(1,1,1,2'd3,64'd0,64'd0,0,1,4'b1010,0,"R11_stcx2");
        send(0,0,1,2'd0,64'd0,64'd0,0,0,4'd0,0,"R1_idle");

        @(negedge clk);
        i_valid = 0; i_rec = 0; i_so_clr = 0;
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule